// File: doc/BRIEF.md
# Four-Channel-Pair PWM and Capture Timer

This block holds four timer subsystems that run independently of each other. A mode field sets each one to drive two separate 8-bit PWM outputs, to join its counter halves into one 16-bit PWM channel, or to run a 16-bit free counter that two input-capture channels sample on external edges. An 8-bit prescaler sits ahead of each counter, so each counter advances once every (prescale+1) clocks.

Software reaches the unit through a flat register port. One write strobe is sampled on the clock edge. Reads are combinational from the current address. New period and duty values wait in buffer registers and the counter takes them at its next wrap, so a write in the middle of a period never cuts an output pulse short. Each capture channel has a sticky flag that also serves as an interrupt line.

Top module: `vtu_top`

## Requirements
- R1: After reset every PWM output and every capture flag is low, and every register of every subsystem reads zero.
- R2: The address bits above bit 2 pick the subsystem and bits [2:0] pick the register. The registers are: 0 mode, 1 prescale, 2 period, 3 duty, 4 capture A, 5 capture B, 6 flags. In the mode register, bits [1:0] give the mode (0 dual 8-bit PWM, 1 16-bit PWM, 2 capture, 3 stopped), bit 2 makes channel A capture on falling edges and bit 3 does the same for channel B. Period, duty, prescale and mode read back the last value written. Channel A of subsystem s uses pin bit 2s and channel B uses bit 2s+1, on pwm_o, cap_i and cap_irq_o alike.
- R3: In dual 8-bit mode, channel A uses the low byte of period and duty and channel B uses the high byte, each with its own 8-bit counter. Each counter steps 0 up to its period and then returns to 0. The output is high while the counter is below the duty.
- R4: In 16-bit mode, channel A uses the full 16-bit period, duty and counter under the same rule, and channel B stays low.
- R5: The counter advances once every (prescale+1) clock cycles.
- R6: A duty of zero keeps an output low. A duty above the period keeps an output high.
- R7: A write to period or duty takes effect at the next counter wrap, or at a mode write, whichever comes first.
- R8: Any write to the mode register clears that subsystem's counter and prescaler and loads the buffered period and duty.
- R9: In capture mode the 16-bit counter runs freely and wraps past its top value. Each capture input passes through two synchronizing flip-flops. If an input changes between clock edges k and k+1, the stored value is the count held after edge k+2. In the other modes no capture happens and PWM outputs only appear in the two PWM modes.
- R10: A capture happens only on the edge polarity selected for that channel. The flag stays set until software writes 1 to its bit, and a capture in the same cycle as a clear takes priority.
- R11: In the stopped mode the counter holds and both outputs of the subsystem stay low.
- R12: A write to one subsystem does not change the registers, flags or outputs of any other subsystem.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Subsystem select (upper bits) and register select (bits 2:0) |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i |
| cap_i | input | 8 | Capture inputs, two per subsystem |
| pwm_o | output | 8 | PWM outputs, two per subsystem |
| cap_irq_o | output | 8 | Sticky capture flags, two per subsystem |

## Verification
The PWM function is run with a table of settings. The table covers dual mode with distinct periods on the two byte halves, which shows whether the halves are wired up independently. It covers 16-bit periods above 255, which shows whether the counters are properly joined. It covers prescale values of 0, 1, 2, 3 and 255, which show the divide ratio, and duty values of zero and above the period, which show the saturating cases. Each entry counts high cycles over a window of two whole periods, so the count pins down both the period and the duty. Directed sequences then write the duty in the middle of a period, rewrite the mode while a counter is running, and give the capture channels edges of both polarities at known cycle offsets, so the stored count shows the synchronizer latency.

// File: rtl/vtu_pkg.sv
package vtu_pkg;
  typedef enum logic [1:0] {
    MODE_DUAL8 = 2'd0,
    MODE_PWM16 = 2'd1,
    MODE_CAPT  = 2'd2,
    MODE_STOP  = 2'd3
  } tmode_e;

  localparam logic [2:0] REG_MODE = 3'd0;
  localparam logic [2:0] REG_PSC  = 3'd1;
  localparam logic [2:0] REG_PER  = 3'd2;
  localparam logic [2:0] REG_DUTY = 3'd3;
  localparam logic [2:0] REG_CAPA = 3'd4;
  localparam logic [2:0] REG_CAPB = 3'd5;
  localparam logic [2:0] REG_FLAG = 3'd6;
endpackage

// File: rtl/vtu_prescaler.sv
module vtu_prescaler #(
  parameter int PS_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic [PS_W-1:0] div_i,
  output logic            tick_o
);
  localparam logic [PS_W-1:0] ONE = PS_W'(1);
  logic [PS_W-1:0] ps_q;

  // >= so a smaller divisor written mid-count cannot stall the count
  assign tick_o = ps_q >= div_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               ps_q <= '0;
    else if (clr_i || tick_o)  ps_q <= '0;
    else                       ps_q <= ps_q + ONE;
  end
endmodule

// File: rtl/vtu_cap_chan.sv
module vtu_cap_chan (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic fall_i,
  output logic edge_o
);
  logic s1_q, s2_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      s1_q   <= pin_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign edge_o = fall_i ? (prev_q & ~s2_q) : (s2_q & ~prev_q);
endmodule

// File: rtl/vtu_subsys.sv
module vtu_subsys
  import vtu_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PS_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [2:0]       reg_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  input  logic [1:0]       cap_i,
  output logic [1:0]       pwm_o,
  output logic [1:0]       irq_o,
  output logic [1:0]       mode_o
);
  localparam int HW = CNT_W / 2;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [HW-1:0]    HONE = HW'(1);

  tmode_e                     mode_q;
  logic [1:0]                 fall_q;
  logic [PS_W-1:0]            psc_q;
  logic [CNT_W-1:0]           per_buf, duty_buf, per_act, duty_act, cnt_q;
  logic [1:0][CNT_W-1:0]      cap_q;
  logic [1:0]                 flag_q, edge_w;
  logic                       mode_wr, tick;

  assign mode_wr = wr_i && (reg_i == REG_MODE);

  vtu_prescaler #(.PS_W(PS_W)) u_psc (
    .clk_i (clk_i), .rst_ni(rst_ni), .clr_i(mode_wr), .div_i(psc_q), .tick_o(tick)
  );

  for (genvar c = 0; c < 2; c++) begin : g_cap
    vtu_cap_chan u_chan (
      .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(cap_i[c]), .fall_i(fall_q[c]), .edge_o(edge_w[c])
    );
  end

  // configuration registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= MODE_DUAL8;
      fall_q   <= '0;
      psc_q    <= '0;
      per_buf  <= '0;
      duty_buf <= '0;
    end else if (wr_i) begin
      case (reg_i)
        REG_MODE: begin
          mode_q <= tmode_e'(wdata_i[1:0]);
          fall_q <= wdata_i[3:2];
        end
        REG_PSC:  psc_q    <= wdata_i[PS_W-1:0];
        REG_PER:  per_buf  <= wdata_i;
        REG_DUTY: duty_buf <= wdata_i;
        default: ;
      endcase
    end
  end

  // counters and active (shadowed) period/duty
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      per_act  <= '0;
      duty_act <= '0;
    end else if (mode_wr) begin
      cnt_q    <= '0;
      per_act  <= per_buf;
      duty_act <= duty_buf;
    end else if (tick) begin
      case (mode_q)
        MODE_DUAL8: begin
          if (cnt_q[HW-1:0] == per_act[HW-1:0]) begin
            cnt_q[HW-1:0]    <= '0;
            per_act[HW-1:0]  <= per_buf[HW-1:0];
            duty_act[HW-1:0] <= duty_buf[HW-1:0];
          end else begin
            cnt_q[HW-1:0] <= cnt_q[HW-1:0] + HONE;
          end
          if (cnt_q[CNT_W-1:HW] == per_act[CNT_W-1:HW]) begin
            cnt_q[CNT_W-1:HW]    <= '0;
            per_act[CNT_W-1:HW]  <= per_buf[CNT_W-1:HW];
            duty_act[CNT_W-1:HW] <= duty_buf[CNT_W-1:HW];
          end else begin
            cnt_q[CNT_W-1:HW] <= cnt_q[CNT_W-1:HW] + HONE;
          end
        end
        MODE_PWM16: begin
          if (cnt_q == per_act) begin
            cnt_q    <= '0;
            per_act  <= per_buf;
            duty_act <= duty_buf;
          end else begin
            cnt_q <= cnt_q + ONE;
          end
        end
        MODE_CAPT: cnt_q <= cnt_q + ONE;
        default: ;
      endcase
    end
  end

  // capture registers and sticky flags; capture wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q  <= '0;
      flag_q <= '0;
    end else begin
      for (int c = 0; c < 2; c++) begin
        if (mode_q == MODE_CAPT && edge_w[c]) begin
          cap_q[c]  <= cnt_q;
          flag_q[c] <= 1'b1;
        end else if (wr_i && reg_i == REG_FLAG && wdata_i[c]) begin
          flag_q[c] <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    pwm_o = '0;
    case (mode_q)
      MODE_DUAL8: pwm_o = {cnt_q[CNT_W-1:HW] < duty_act[CNT_W-1:HW],
                           cnt_q[HW-1:0]     < duty_act[HW-1:0]};
      MODE_PWM16: pwm_o[0] = cnt_q < duty_act;
      default: ;
    endcase
  end

  always_comb begin
    rdata_o = '0;
    case (reg_i)
      REG_MODE: begin
        rdata_o[1:0] = mode_q;
        rdata_o[3:2] = fall_q;
      end
      REG_PSC:  rdata_o[PS_W-1:0] = psc_q;
      REG_PER:  rdata_o = per_buf;
      REG_DUTY: rdata_o = duty_buf;
      REG_CAPA: rdata_o = cap_q[0];
      REG_CAPB: rdata_o = cap_q[1];
      REG_FLAG: rdata_o[1:0] = flag_q;
      default: ;
    endcase
  end

  assign irq_o  = flag_q;
  assign mode_o = mode_q;
endmodule

// File: rtl/vtu_top.sv
module vtu_top #(
  parameter int N_SUB  = 4,
  parameter int CNT_W  = 16,
  parameter int PS_W   = 8,
  localparam int SEL_W  = (N_SUB > 1) ? $clog2(N_SUB) : 1,
  localparam int ADDR_W = SEL_W + 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [CNT_W-1:0]   wdata_i,
  output logic [CNT_W-1:0]   rdata_o,
  input  logic [2*N_SUB-1:0] cap_i,
  output logic [2*N_SUB-1:0] pwm_o,
  output logic [2*N_SUB-1:0] cap_irq_o
);
  logic [SEL_W-1:0]          sel;
  logic [CNT_W-1:0]          sub_rd [N_SUB];
  logic [N_SUB-1:0][1:0]     mode_w;

  assign sel = addr_i[ADDR_W-1:3];

  for (genvar s = 0; s < N_SUB; s++) begin : g_sub
    vtu_subsys #(.CNT_W(CNT_W), .PS_W(PS_W)) u_sub (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (wr_en_i && (sel == SEL_W'(s))),
      .reg_i  (addr_i[2:0]),
      .wdata_i(wdata_i),
      .rdata_o(sub_rd[s]),
      .cap_i  (cap_i[2*s +: 2]),
      .pwm_o  (pwm_o[2*s +: 2]),
      .irq_o  (cap_irq_o[2*s +: 2]),
      .mode_o (mode_w[s])
    );
  end

  assign rdata_o = sub_rd[sel];
endmodule

// File: rtl/vtu_top_chk.sv
module vtu_top_chk
  import vtu_pkg::*;
#(
  parameter int N_SUB  = 4,
  parameter int CNT_W  = 16,
  parameter int SEL_W  = 2,
  parameter int ADDR_W = 5
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [CNT_W-1:0]   wdata_i,
  input logic [2*N_SUB-1:0] pwm_o,
  input logic [2*N_SUB-1:0] cap_irq_o,
  input logic [N_SUB-1:0][1:0] mode_w
);
  for (genvar s = 0; s < N_SUB; s++) begin : g_s
    AST_PWM16_SPARE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mode_w[s] == MODE_PWM16 |-> !pwm_o[2*s+1]); // R4
    AST_STOP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mode_w[s] == MODE_STOP |-> pwm_o[2*s +: 2] == 2'b00); // R11
    AST_CAPT_NO_PWM: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mode_w[s] == MODE_CAPT |-> pwm_o[2*s +: 2] == 2'b00); // R9
    for (genvar c = 0; c < 2; c++) begin : g_c
      AST_FLAG_CLEAR_ONLY_BY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(cap_irq_o[2*s+c]) |-> $past(wr_en_i && addr_i[ADDR_W-1:3] == SEL_W'(s)
                                          && addr_i[2:0] == REG_FLAG && wdata_i[c])); // R10
      AST_FLAG_SET_IN_CAPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(cap_irq_o[2*s+c]) |-> $past(mode_w[s] == MODE_CAPT)); // R9
    end
  end
endmodule

bind vtu_top vtu_top_chk #(.N_SUB(N_SUB), .CNT_W(CNT_W), .SEL_W(SEL_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
  .pwm_o(pwm_o), .cap_irq_o(cap_irq_o), .mode_w(mode_w)
);

// File: tb/vtu_top_bench.sv
module vtu_top_bench;
  import vtu_pkg::*;

  localparam int N_SUB = 4;
  localparam int CNT_W = 16;
  localparam int ADDR_W = 5;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [CNT_W-1:0]  wdata = '0;
  logic [CNT_W-1:0]  rdata;
  logic [7:0]        cap_in = '0;
  logic [7:0]        pwm, irq;
  int cyc = 0;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  vtu_top u_vtu_top (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .cap_i(cap_in), .pwm_o(pwm), .cap_irq_o(irq)
  );

  // {sub[1:0], mode[1:0], psc[7:0], period[15:0], duty[15:0]}
  localparam logic [43:0] VEC [6] = '{
    {2'd0, 2'd0, 8'd0,   16'h0409, 16'h0203},
    {2'd1, 2'd0, 8'd2,   16'h0705, 16'h0800},
    {2'd2, 2'd1, 8'd0,   16'd299,  16'd100},
    {2'd3, 2'd1, 8'd3,   16'd19,   16'd20},
    {2'd0, 2'd1, 8'd255, 16'd3,    16'd1},
    {2'd2, 2'd0, 8'd1,   16'h00FF, 16'h0080}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // caller sits at a negedge; returns at the negedge after the write edge
  task automatic wr(input int sub, input logic [2:0] r, input logic [15:0] d);
    addr  = {sub[1:0], r};
    wdata = d;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int sub, input logic [2:0] r, output logic [15:0] d);
    addr = {sub[1:0], r};
    #1;
    d = rdata;
  endtask

  task automatic wait_to(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  function automatic int min2(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [15:0] d;
    int w, t;

    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 pwm", pwm, 0);
    chk("R1 irq", irq, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int r = 0; r < 7; r++) begin
      rd(3, r[2:0], d);
      chk("R1 reg", d, 0);
    end

    // table walk: PWM high-cycle counts over two periods
    for (int v = 0; v < 6; v++) begin
      logic [43:0] e;
      int sub, mode, psc, pa, pb, da, db, ta, tb, ha, hb, ca, cb, n;
      string ra, rb;
      e = VEC[v];
      sub = int'(e[43:42]); mode = int'(e[41:40]); psc = int'(e[39:32]);
      wr(sub, REG_PSC, {8'd0, e[39:32]});
      wr(sub, REG_PER, e[31:16]);
      wr(sub, REG_DUTY, e[15:0]);
      wr(sub, REG_MODE, {14'd0, e[41:40]});
      if (mode == 0) begin
        pa = int'(e[23:16]); pb = int'(e[31:24]);
        da = int'(e[7:0]);   db = int'(e[15:8]);
        ta = 2 * (pa + 1) * (psc + 1);
        tb = 2 * (pb + 1) * (psc + 1);
        ha = 2 * min2(da, pa + 1) * (psc + 1);
        hb = 2 * min2(db, pb + 1) * (psc + 1);
        ra = "R3 chA"; rb = "R3 chB";
      end else begin
        pa = int'(e[31:16]); da = int'(e[15:0]);
        ta = 2 * (pa + 1) * (psc + 1);
        tb = ta;
        ha = 2 * min2(da, pa + 1) * (psc + 1);
        hb = 0;
        ra = "R4 ch"; rb = "R4 spare";
      end
      if (ha == 0 || ha == ta) ra = "R6 chA";
      if (mode == 0 && (hb == 0 || hb == tb)) rb = "R6 chB";
      ca = 0; cb = 0;
      n = (ta > tb) ? ta : tb;
      for (int k = 0; k < n; k++) begin
        if (k < ta && pwm[2*sub]) ca++;
        if (k < tb && pwm[2*sub+1]) cb++;
        @(negedge clk);
      end
      chk(ra, ca, ha);
      chk(rb, cb, hb);
    end

    // R7: buffered duty on subsystem 0, 16-bit, period 10 clocks
    wr(0, REG_PSC, 16'd0);
    wr(0, REG_PER, 16'd9);
    wr(0, REG_DUTY, 16'd5);
    wr(0, REG_MODE, 16'd1);
    w = cyc;
    wr(0, REG_DUTY, 16'd8);
    wait_to(w + 6);
    chk("R7 old duty kept", pwm[0], 0);
    wait_to(w + 16);
    chk("R7 new duty after wrap", pwm[0], 1);
    rd(0, REG_DUTY, d);
    chk("R2 duty readback", d, 8);

    // R8 and R5: restart with prescale 3, duty 1 -> high for 4 clocks
    wait_to(w + 18);
    chk("R7 counter at 8", pwm[0], 0);
    wr(0, REG_DUTY, 16'd1);
    wr(0, REG_PSC, 16'd3);
    wr(0, REG_MODE, 16'd1);
    w = cyc;
    chk("R8 restart", pwm[0], 1);
    wait_to(w + 3);
    chk("R5 count held", pwm[0], 1);
    wait_to(w + 4);
    chk("R5 count advanced", pwm[0], 0);
    rd(0, REG_PSC, d);
    chk("R2 psc readback", d, 3);
    rd(0, REG_MODE, d);
    chk("R2 mode readback", d, 1);

    // R9/R10: capture on subsystem 1, A rising, B falling
    wr(1, REG_PSC, 16'd0);
    wr(1, REG_MODE, 16'h000A);
    w = cyc;
    rd(1, REG_MODE, d);
    chk("R2 mode edge bits", d, 16'h000A);
    wait_to(w + 10);
    t = cyc;
    cap_in[2] = 1'b1;
    repeat (5) @(negedge clk);
    rd(1, REG_CAPA, d);
    chk("R9 rising capture value", d, t - w + 2);
    chk("R10 flag A set", irq[2], 1);
    chk("R10 flag B clear", irq[3], 0);
    cap_in[3] = 1'b1;
    repeat (5) @(negedge clk);
    chk("R10 wrong edge no flag", irq[3], 0);
    rd(1, REG_CAPB, d);
    chk("R10 wrong edge no capture", d, 0);
    t = cyc;
    cap_in[3] = 1'b0;
    repeat (5) @(negedge clk);
    rd(1, REG_CAPB, d);
    chk("R9 falling capture value", d, t - w + 2);
    chk("R10 flag B set", irq[3], 1);
    cap_in[2] = 1'b0;
    repeat (5) @(negedge clk);
    rd(1, REG_CAPA, d);
    chk("R10 A ignores falling", d, 12);
    chk("R10 flag A sticky", irq[2], 1);
    wr(1, REG_FLAG, 16'h0001);
    chk("R10 flag A cleared", irq[2], 0);
    chk("R10 flag B kept", irq[3], 1);

    // R11/R12: stop subsystem 3, subsystem 1 untouched
    wr(3, REG_MODE, 16'd3);
    repeat (4) @(negedge clk);
    chk("R11 stopped outputs", pwm[7:6], 0);
    rd(1, REG_CAPB, d);
    chk("R12 other capture kept", d, t - w + 2);
    chk("R12 other flag kept", irq[3], 1);
    rd(1, REG_MODE, d);
    chk("R12 other mode kept", d, 16'h000A);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule